// File: doc/BRIEF.md
# Dual-Rail Reset Sequencer with Manual Reset

This controller drives two processor reset outputs, one for each of two supply rails. An analog comparator sits outside the block for each rail and reports a digital flag that is high while that rail is below its threshold. Each comparator also takes a band-select bit, and the block passes that bit straight through to a select output.

A rail fault that lasts longer than a short noise window asserts that rail's reset and leaves the other rail's reset alone. When the fault clears, the reset stays active for a fixed extension time and then releases. The same extension applies after the block itself comes out of reset.

An active-low pushbutton input is synchronized and debounced. An accepted press asserts both resets for as long as it is held, and both resets then stretch for the extension time after release. A press is only accepted if at least one reset is deasserted at the moment of acceptance. All time windows are given in physical units and converted to cycle counts from a clock-frequency parameter. A polarity parameter selects active-low or active-high outputs.

Top module: `dual_rail_rst_seq`

## Requirements
- R1: A rail flag held high for at least NF_CYC cycles asserts that rail's reset within NF_CYC+6 cycles. The other rail's reset does not change.
- R2: After a rail flag returns low, its reset stays asserted for EXT_CYC cycles and deasserts within EXT_CYC+4 cycles. EXT_CYC = CLK_HZ*EXT_US/1e6.
- R3: A rail flag pulse shorter than NF_CYC cycles has no effect on either output. NF_CYC = CLK_HZ*NOISE_NS/1e9.
- R4: A pushbutton low pulse shorter than MR_CYC cycles has no effect on either output. MR_CYC = CLK_HZ*MR_US/1e6.
- R5: A pushbutton low held for MR_CYC cycles asserts both resets. Both stay asserted while the button is held and for EXT_CYC cycles after it goes high.
- R6: A press is accepted only if, on the cycle it completes MR_CYC low cycles, at least one reset is deasserted. A press completed while both resets are asserted is ignored until the button is released and pressed again.
- R7: While rst_n is low both resets are asserted, and both extension timers are loaded with EXT_CYC.
- R8: band_hi_o equals tol_hi_sel (0 = 5% band, 1 = 10% band). band_lo_o equals tol_lo_sel (0 = 10% band, 1 = 20% band).
- R9: A new accepted fault or press during an extension reloads that channel's timer to the full EXT_CYC count.
- R10: With ACT_HIGH = 0 an asserted reset drives 0. With ACT_HIGH = 1 an asserted reset drives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| rail_fault_hi | input | 1 | Higher rail below threshold (asynchronous) |
| rail_fault_lo | input | 1 | Lower rail below threshold (asynchronous) |
| tol_hi_sel | input | 1 | Band select for the higher rail comparator |
| tol_lo_sel | input | 1 | Band select for the lower rail comparator |
| mr_n | input | 1 | Pushbutton, active low (asynchronous) |
| rst_hi_o | output | 1 | Reset for the higher rail domain |
| rst_lo_o | output | 1 | Reset for the lower rail domain |
| band_hi_o | output | 1 | Comparator band select, higher rail |
| band_lo_o | output | 1 | Comparator band select, lower rail |

## Verification
The bench fires rail glitches and short button taps just under their windows. A design that skipped the noise filter or the debounce would pulse a reset on these. It samples each reset a few cycles before and after the end of the extension, which catches an off-by-much timer and a timer that never reloads on a second fault. It presses the button while both resets are already held by faults and keeps it pressed after the faults clear. A design that arms on the button level, and not on the moment of acceptance, would hold both resets indefinitely. A second instance with the opposite polarity catches an inverted output.

// File: rtl/dual_rail_rst_seq.sv
module dual_rail_rst_seq #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned EXT_US   = 350_000,
  parameter int unsigned MR_US    = 2_000,
  parameter int unsigned NOISE_NS = 2_000,
  parameter bit          ACT_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_fault_hi,
  input  logic rail_fault_lo,
  input  logic tol_hi_sel,
  input  logic tol_lo_sel,
  input  logic mr_n,
  output logic rst_hi_o,
  output logic rst_lo_o,
  output logic band_hi_o,
  output logic band_lo_o
);
  localparam longint EXT_L  = (longint'(CLK_HZ) * longint'(EXT_US)) / 64'sd1000000;
  localparam longint MR_L   = (longint'(CLK_HZ) * longint'(MR_US)) / 64'sd1000000;
  localparam longint NF_L   = (longint'(CLK_HZ) * longint'(NOISE_NS)) / 64'sd1000000000;
  localparam int EXT_CYC = (EXT_L < 1) ? 1 : int'(EXT_L);
  localparam int MR_CYC  = (MR_L < 2) ? 2 : int'(MR_L);
  localparam int NF_CYC  = (NF_L < 1) ? 1 : int'(NF_L);
  localparam int EW = $clog2(EXT_CYC + 1);
  localparam int MW = $clog2(MR_CYC + 1);
  localparam int NW = $clog2(NF_CYC + 1);

  logic [1:0]    s1, s2, qf, act;
  logic          m1, m2, hold;
  logic [MW-1:0] mcnt;
  logic [NW-1:0] flt [2];
  logic [EW-1:0] cnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      m1 <= 1'b1;
      m2 <= 1'b1;
    end else begin
      s1 <= {rail_fault_lo, rail_fault_hi};
      s2 <= s1;
      m1 <= mr_n;
      m2 <= m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= '0;
      hold <= 1'b0;
    end else if (m2) begin
      mcnt <= '0;
      hold <= 1'b0;
    end else begin
      if (mcnt != MW'(MR_CYC)) mcnt <= mcnt + 1'b1;
      if (mcnt == MW'(MR_CYC - 1) && !(&act)) hold <= 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_rail
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flt[g] <= '0;
      else if (!s2[g])                     flt[g] <= '0;
      else if (flt[g] != NW'(NF_CYC))      flt[g] <= flt[g] + 1'b1;
    end
    assign qf[g] = (flt[g] == NW'(NF_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt[g] <= EW'(EXT_CYC);
      else if (qf[g] || hold)   cnt[g] <= EW'(EXT_CYC);
      else if (cnt[g] != '0)    cnt[g] <= cnt[g] - 1'b1;
    end
    assign act[g] = (cnt[g] != '0);

    a_r1_fault_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      qf[g] |=> act[g]);
    a_r2_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act[g]) |-> (!$past(qf[g]) && !$past(hold)));
    a_r3_filter_seen: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qf[g]) |-> $past(s2[g]));
  end

  a_r5_both_held: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (act[0] && act[1]));
  a_r6_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !($past(act[0]) && $past(act[1])));

  assign rst_hi_o  = ACT_HIGH ? act[0] : ~act[0];
  assign rst_lo_o  = ACT_HIGH ? act[1] : ~act[1];
  assign band_hi_o = tol_hi_sel;
  assign band_lo_o = tol_lo_sel;
endmodule

// File: tb/tb_dual_rail_rst_seq.sv
module tb_dual_rail_rst_seq;
  localparam int EXT = 60;
  localparam int MR  = 10;
  localparam int NF  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_hi = 1'b0, f_lo = 1'b0, t_hi = 1'b0, t_lo = 1'b0, mr_n = 1'b1;
  logic r_hi, r_lo, b_hi, b_lo, a_hi, a_lo, ab_hi, ab_lo;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_rail_rst_seq #(.CLK_HZ(1_000_000), .EXT_US(EXT), .MR_US(MR), .NOISE_NS(4000), .ACT_HIGH(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .rail_fault_hi(f_hi), .rail_fault_lo(f_lo),
    .tol_hi_sel(t_hi), .tol_lo_sel(t_lo), .mr_n(mr_n),
    .rst_hi_o(r_hi), .rst_lo_o(r_lo), .band_hi_o(b_hi), .band_lo_o(b_lo));

  dual_rail_rst_seq #(.CLK_HZ(1_000_000), .EXT_US(EXT), .MR_US(MR), .NOISE_NS(4000), .ACT_HIGH(1'b1)) dut_ah (
    .clk(clk), .rst_n(rst_n), .rail_fault_hi(f_hi), .rail_fault_lo(f_lo),
    .tol_hi_sel(t_hi), .tol_lo_sel(t_lo), .mr_n(mr_n),
    .rst_hi_o(a_hi), .rst_lo_o(a_lo), .band_hi_o(ab_hi), .band_lo_o(ab_lo));

  function automatic logic lvl(input bit asserted, input bit ah);
    return ah ? asserted : !asserted;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_both(input string req, input bit hi_on, input bit lo_on);
    chk(req, r_hi, lvl(hi_on, 1'b0));
    chk(req, r_lo, lvl(lo_on, 1'b0));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(3);
    // R7 / R10: reset state
    chk_both("R7", 1'b1, 1'b1);
    chk("R10", a_hi, lvl(1'b1, 1'b1));
    chk("R10", a_lo, lvl(1'b1, 1'b1));
    rst_n = 1'b1;
    wait_cyc(2);
    chk_both("R7", 1'b1, 1'b1);
    // R2: power-up stretch ends
    wait_cyc(EXT - 6);
    chk_both("R2", 1'b1, 1'b1);
    wait_cyc(12);
    chk_both("R2", 1'b0, 1'b0);
    chk("R10", a_hi, lvl(1'b0, 1'b1));

    // R1: higher rail fault, lower unaffected
    f_hi = 1'b1;
    wait_cyc(NF + 6);
    chk_both("R1", 1'b1, 1'b0);
    f_hi = 1'b0;
    wait_cyc(EXT - 3);
    chk_both("R2", 1'b1, 1'b0);
    wait_cyc(9);
    chk_both("R2", 1'b0, 1'b0);

    // R1: lower rail fault, higher unaffected
    f_lo = 1'b1;
    wait_cyc(NF + 6);
    chk_both("R1", 1'b0, 1'b1);
    f_lo = 1'b0;
    wait_cyc(EXT + 6);
    chk_both("R2", 1'b0, 1'b0);

    // R9: a second fault during the extension reloads the timer
    f_hi = 1'b1;
    wait_cyc(NF + 6);
    f_hi = 1'b0;
    wait_cyc(EXT / 2);
    f_hi = 1'b1;
    wait_cyc(NF + 2);
    f_hi = 1'b0;
    wait_cyc(EXT - 3);
    chk("R9", r_hi, lvl(1'b1, 1'b0));
    wait_cyc(9);
    chk("R9", r_hi, lvl(1'b0, 1'b0));

    // R5: accepted press asserts both resets
    mr_n = 1'b0;
    wait_cyc(MR + 6);
    chk_both("R5", 1'b1, 1'b1);
    wait_cyc(EXT + 10);
    chk_both("R5", 1'b1, 1'b1);
    mr_n = 1'b1;
    wait_cyc(EXT - 3);
    chk_both("R5", 1'b1, 1'b1);
    wait_cyc(9);
    chk_both("R5", 1'b0, 1'b0);

    // R6: a press while both resets are asserted is ignored
    f_hi = 1'b1; f_lo = 1'b1;
    wait_cyc(NF + 6);
    mr_n = 1'b0;
    wait_cyc(MR + 8);
    f_hi = 1'b0; f_lo = 1'b0;
    wait_cyc(EXT + 10);
    chk_both("R6", 1'b0, 1'b0);
    mr_n = 1'b1;
    wait_cyc(6);

    // R6 / R9: a press while only one reset is asserted is accepted and reloads it
    f_hi = 1'b1;
    wait_cyc(NF + 6);
    f_hi = 1'b0;
    wait_cyc(10);
    mr_n = 1'b0;
    wait_cyc(MR + 6);
    chk_both("R6", 1'b1, 1'b1);
    mr_n = 1'b1;
    wait_cyc(EXT - 3);
    chk_both("R9", 1'b1, 1'b1);
    wait_cyc(9);
    chk_both("R9", 1'b0, 1'b0);

    // Random: band selects, rail glitches, short taps
    for (int it = 0; it < 12; it++) begin
      bit bad;
      int len;
      bit rail;
      t_hi = 1'($urandom % 2);
      t_lo = 1'($urandom % 2);
      #1;
      chk("R8", b_hi, t_hi);
      chk("R8", b_lo, t_lo);
      rail = 1'($urandom % 2);
      len = $urandom_range(NF - 1, 1);
      if (rail) f_lo = 1'b1; else f_hi = 1'b1;
      bad = 1'b0;
      for (int c = 0; c < len; c++) begin
        wait_cyc(1);
        if (r_hi !== 1'b1 || r_lo !== 1'b1) bad = 1'b1;
      end
      f_hi = 1'b0; f_lo = 1'b0;
      for (int c = 0; c < NF + 8; c++) begin
        wait_cyc(1);
        if (r_hi !== 1'b1 || r_lo !== 1'b1) bad = 1'b1;
      end
      chk("R3", bad, 1'b0);
      len = $urandom_range(MR - 2, 1);
      mr_n = 1'b0;
      bad = 1'b0;
      for (int c = 0; c < len; c++) begin
        wait_cyc(1);
        if (r_hi !== 1'b1 || r_lo !== 1'b1) bad = 1'b1;
      end
      mr_n = 1'b1;
      for (int c = 0; c < MR + 6; c++) begin
        wait_cyc(1);
        if (r_hi !== 1'b1 || r_lo !== 1'b1) bad = 1'b1;
      end
      chk("R4", bad, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule